// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block sits behind the receive MAC and gives one accept-or-drop verdict for every incoming Ethernet frame. It watches the frame as a stream of octets, framed by a start strobe on the first octet and an end strobe on the last one. It records the destination address (octets 0 to 5) and the source address (octets 6 to 11). At the end of the frame it weighs them against a programmed 48-bit station address, a 64-bit multicast hash table and a set of control bits.

The verdict comes out as a one-cycle valid pulse together with an accept flag, one cycle after the end-of-frame octet. The filtering modes are unicast match, broadcast, multicast (either all groups or groups qualified by the hash table), promiscuous, inverse filtering and self-sourced drop. A receive enable is sampled only at the start of each frame, so changing it in the middle of a frame never affects the frame in progress.

Top module: `rxf_top`

## Requirements
- R1: With the unicast enable set and inverse mode clear, a unicast frame (bit 0 of destination octet 0 clear) whose destination equals the station address is accepted. A unicast frame to any other address is dropped. Octet 0 of the destination matches station address bits 47:40.
- R2: With the broadcast enable set, a frame whose destination is all ones is accepted.
- R3: With the all-multicast enable set, every frame with bit 0 of destination octet 0 set is accepted, and this includes broadcast frames.
- R4: With the hash-multicast enable set, a non-broadcast multicast frame is accepted when the hash table bit is set. The table bit is selected by bits 31:26 of a CRC-32 taken over the six destination octets. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones, takes each octet LSB first, and is not inverted at the end. A clear table bit gives a drop.
- R5: With promiscuous mode set, every enabled frame of at least 12 octets is accepted, whatever its addresses are.
- R6: With self-source drop set, a frame whose source address equals the station address is dropped. Promiscuous mode is the only setting that overrides this drop.
- R7: Inverse mode inverts the unicast and multicast match result for frames that are not broadcast. It never changes the outcome for a broadcast frame, and it never changes the outcome under promiscuous mode.
- R8: The receive enable is sampled on the start octet. A frame that starts while the enable is clear gets a drop verdict. Changing the enable during a frame does not change that frame's verdict.
- R9: Exactly one verdict pulse is produced for each frame, in the cycle after the end-of-frame octet. The accept flag is low whenever no verdict is valid.
- R10: A frame shorter than 12 octets is always dropped, even in promiscuous mode.
- R11: After reset, no verdict is valid and the accept flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_sof | input | 1 | First octet of a frame (qualified by in_vld) |
| in_eof | input | 1 | Last octet of a frame (qualified by in_vld) |
| in_vld | input | 1 | Octet valid |
| in_data | input | 8 | Octet value |
| station_addr | input | 48 | Station address, bits 47:40 compared with octet 0 |
| hash_table | input | 64 | Multicast hash table |
| cfg_rx_en | input | 1 | Receive enable, sampled on the start octet |
| cfg_uc_en | input | 1 | Unicast match enable |
| cfg_bc_en | input | 1 | Broadcast enable |
| cfg_mc_all_en | input | 1 | Accept all multicast |
| cfg_mc_hash_en | input | 1 | Accept multicast that hits the hash table |
| cfg_promisc | input | 1 | Accept all frames |
| cfg_inverse | input | 1 | Inverse filtering |
| cfg_sa_drop | input | 1 | Drop frames sourced from the station address |
| verdict_vld | output | 1 | One-cycle verdict pulse |
| verdict_accept | output | 1 | Accept (1) or drop (0) |

## Verification
The bench builds the block with its default parameters: a 12-octet minimum length and a 6-bit hash index. Random frame lengths from 1 to 20 octets therefore fall on both sides of the length limit. The 64-entry hash table is small enough that random tables give both hits and misses for random multicast groups. Directed frames cover the limit exactly at 11 and 12 octets, inverse mode applied to broadcast frames, promiscuous mode overriding the self-source drop, and the receive enable toggled both before a frame and in the middle of one.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int MAC_W     = 48;
    localparam int MAC_BYTES = MAC_W / 8;

    typedef struct packed {
        logic rx_en;
        logic uc_en;
        logic bc_en;
        logic mc_all_en;
        logic mc_hash_en;
        logic promisc;
        logic inverse;
        logic sa_drop;
    } rxf_cfg_t;

    typedef enum logic [1:0] {
        DK_UNICAST   = 2'd0,
        DK_MULTICAST = 2'd1,
        DK_BROADCAST = 2'd2
    } dest_kind_t;

    // One octet of reflected CRC-32, LSB first, no final inversion.
    function automatic logic [31:0] crc32_octet(logic [31:0] c_in, logic [7:0] oct);
        logic [31:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ oct[i]) c = (c >> 1) ^ 32'hEDB8_8320;
            else               c = c >> 1;
        end
        return c;
    endfunction

    function automatic dest_kind_t classify_dest(logic [MAC_W-1:0] da);
        if (&da)         return DK_BROADCAST;
        else if (da[40]) return DK_MULTICAST;
        else             return DK_UNICAST;
    endfunction

endpackage

// File: rtl/rxf_frame_track.sv
module rxf_frame_track #(
    parameter int MIN_LEN = 12,
    parameter int CNT_W   = $clog2(MIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_vld,
    input  logic             rx_en,
    output logic             octet_take,
    output logic [CNT_W-1:0] octet_pos,
    output logic             frame_end,
    output logic             len_ok,
    output logic             en_eff
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MIN_LEN);

    logic             active_q;
    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign octet_take = in_vld & (in_sof | active_q);
    assign octet_pos  = in_sof ? '0 : cnt_q;
    assign cnt_inc    = (octet_pos == LIMIT) ? LIMIT : octet_pos + 1'b1;
    assign frame_end  = octet_take & in_eof;
    assign len_ok     = (cnt_inc >= LIMIT);
    assign en_eff     = in_sof ? rx_en : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            en_q     <= 1'b0;
            cnt_q    <= '0;
        end else if (octet_take) begin
            active_q <= ~in_eof;
            cnt_q    <= cnt_inc;
            if (in_sof) en_q <= rx_en;
        end
    end

endmodule

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture
    import rxf_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             octet_take,
    input  logic [CNT_W-1:0] octet_pos,
    input  logic [7:0]       in_data,
    output logic [MAC_W-1:0] da_next,
    output logic [MAC_W-1:0] sa_next
);
    logic [MAC_W-1:0] da_q;
    logic [MAC_W-1:0] sa_q;

    for (genvar k = 0; k < MAC_BYTES; k++) begin : g_lane
        localparam int HI = MAC_W - 1 - 8 * k;
        logic da_hit;
        logic sa_hit;
        assign da_hit = octet_take & (octet_pos == CNT_W'(k));
        assign sa_hit = octet_take & (octet_pos == CNT_W'(k + MAC_BYTES));
        assign da_next[HI -: 8] = da_hit ? in_data : da_q[HI -: 8];
        assign sa_next[HI -: 8] = sa_hit ? in_data : sa_q[HI -: 8];

        always_ff @(posedge clk) begin
            if (rst) begin
                da_q[HI -: 8] <= '0;
                sa_q[HI -: 8] <= '0;
            end else begin
                da_q[HI -: 8] <= da_next[HI -: 8];
                sa_q[HI -: 8] <= sa_next[HI -: 8];
            end
        end
    end

endmodule

// File: rtl/rxf_hash.sv
module rxf_hash
    import rxf_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int HASH_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 octet_take,
    input  logic [CNT_W-1:0]     octet_pos,
    input  logic [7:0]           in_data,
    output logic [HASH_BITS-1:0] hash_idx
);
    logic [31:0] crc_q;
    logic [31:0] crc_seed;
    logic [31:0] crc_next;

    assign crc_seed = (octet_pos == '0) ? 32'hFFFF_FFFF : crc_q;
    assign crc_next = (octet_take && octet_pos < CNT_W'(MAC_BYTES))
                    ? crc32_octet(crc_seed, in_data) : crc_q;
    assign hash_idx = crc_next[31 -: HASH_BITS];

    always_ff @(posedge clk) begin
        if (rst) crc_q <= 32'hFFFF_FFFF;
        else     crc_q <= crc_next;
    end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
    import rxf_pkg::*;
#(
    parameter int HASH_BITS = 6,
    parameter int TBL_W     = 1 << HASH_BITS
) (
    input  rxf_cfg_t             cfg,
    input  logic                 en_eff,
    input  logic                 len_ok,
    input  logic [MAC_W-1:0]     da,
    input  logic [MAC_W-1:0]     sa,
    input  logic [MAC_W-1:0]     station,
    input  logic [TBL_W-1:0]     table_bits,
    input  logic [HASH_BITS-1:0] hash_idx,
    output logic                 accept
);
    dest_kind_t kind;
    logic uc_hit, mc_hit, bc_hit, match, sel_match, self_src;

    always_comb begin
        kind      = classify_dest(da);
        uc_hit    = (kind == DK_UNICAST) & cfg.uc_en & (da == station);
        mc_hit    = (kind == DK_MULTICAST)
                  & (cfg.mc_all_en | (cfg.mc_hash_en & table_bits[hash_idx]));
        bc_hit    = (kind == DK_BROADCAST) & (cfg.bc_en | cfg.mc_all_en);
        match     = uc_hit | mc_hit;
        sel_match = (kind != DK_BROADCAST) & (cfg.inverse ? ~match : match);
        self_src  = cfg.sa_drop & (sa == station);
        accept    = en_eff & len_ok
                  & (cfg.promisc | (~self_src & (bc_hit | sel_match)));
    end

endmodule

// File: rtl/rxf_top.sv
module rxf_top
    import rxf_pkg::*;
#(
    parameter int MIN_LEN   = 12,
    parameter int HASH_BITS = 6,
    localparam int TBL_W    = 1 << HASH_BITS,
    localparam int CNT_W    = $clog2(MIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             in_vld,
    input  logic [7:0]       in_data,
    input  logic [MAC_W-1:0] station_addr,
    input  logic [TBL_W-1:0] hash_table,
    input  logic             cfg_rx_en,
    input  logic             cfg_uc_en,
    input  logic             cfg_bc_en,
    input  logic             cfg_mc_all_en,
    input  logic             cfg_mc_hash_en,
    input  logic             cfg_promisc,
    input  logic             cfg_inverse,
    input  logic             cfg_sa_drop,
    output logic             verdict_vld,
    output logic             verdict_accept
);
    rxf_cfg_t             cfg;
    logic                 octet_take, frame_end, len_ok, en_eff, accept;
    logic [CNT_W-1:0]     octet_pos;
    logic [MAC_W-1:0]     da_next, sa_next;
    logic [HASH_BITS-1:0] hash_idx;

    assign cfg = '{rx_en: cfg_rx_en, uc_en: cfg_uc_en, bc_en: cfg_bc_en,
                   mc_all_en: cfg_mc_all_en, mc_hash_en: cfg_mc_hash_en,
                   promisc: cfg_promisc, inverse: cfg_inverse, sa_drop: cfg_sa_drop};

    rxf_frame_track #(.MIN_LEN(MIN_LEN), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst(rst), .in_sof(in_sof), .in_eof(in_eof), .in_vld(in_vld),
        .rx_en(cfg.rx_en), .octet_take(octet_take), .octet_pos(octet_pos),
        .frame_end(frame_end), .len_ok(len_ok), .en_eff(en_eff)
    );

    rxf_addr_capture #(.CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst(rst), .octet_take(octet_take), .octet_pos(octet_pos),
        .in_data(in_data), .da_next(da_next), .sa_next(sa_next)
    );

    rxf_hash #(.CNT_W(CNT_W), .HASH_BITS(HASH_BITS)) u_hash (
        .clk(clk), .rst(rst), .octet_take(octet_take), .octet_pos(octet_pos),
        .in_data(in_data), .hash_idx(hash_idx)
    );

    rxf_decide #(.HASH_BITS(HASH_BITS)) u_dec (
        .cfg(cfg), .en_eff(en_eff), .len_ok(len_ok), .da(da_next), .sa(sa_next),
        .station(station_addr), .table_bits(hash_table), .hash_idx(hash_idx),
        .accept(accept)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_vld    <= 1'b0;
            verdict_accept <= 1'b0;
        end else begin
            verdict_vld    <= frame_end;
            verdict_accept <= frame_end & accept;
        end
    end

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int MIN_LEN = 12
) (
    input logic clk,
    input logic rst,
    input logic in_sof,
    input logic in_eof,
    input logic in_vld,
    input logic cfg_rx_en,
    input logic cfg_promisc,
    input logic verdict_vld,
    input logic verdict_accept
);
    logic        ck_active, ck_en;
    logic [15:0] ck_len;
    logic [15:0] cur_len;
    logic        ck_take, ck_end, cur_en;

    assign ck_take = in_vld & (in_sof | ck_active);
    assign ck_end  = ck_take & in_eof;
    assign cur_len = in_sof ? 16'd1 : ((ck_len == 16'hFFFF) ? ck_len : ck_len + 16'd1);
    assign cur_en  = in_sof ? cfg_rx_en : ck_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_active <= 1'b0;
            ck_en     <= 1'b0;
            ck_len    <= '0;
        end else if (ck_take) begin
            ck_active <= ~in_eof;
            ck_len    <= cur_len;
            if (in_sof) ck_en <= cfg_rx_en;
        end
    end

    assert_verdict_follows_end_R9: assert property (@(posedge clk) disable iff (rst)
        ck_end |=> verdict_vld);

    assert_verdict_only_after_end_R9: assert property (@(posedge clk) disable iff (rst)
        !ck_end |=> !verdict_vld);

    assert_accept_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
        !verdict_vld |-> !verdict_accept);

    assert_short_frame_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (ck_end && cur_len < 16'(MIN_LEN)) |=> !verdict_accept);

    assert_disabled_frame_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (ck_end && !cur_en) |=> !verdict_accept);

    assert_promisc_accepts_R5: assert property (@(posedge clk) disable iff (rst)
        (ck_end && cur_en && cfg_promisc && cur_len >= 16'(MIN_LEN)) |=> verdict_accept);

endmodule

bind rxf_top rxf_checker #(.MIN_LEN(MIN_LEN)) u_rxf_checker (
    .clk(clk), .rst(rst), .in_sof(in_sof), .in_eof(in_eof), .in_vld(in_vld),
    .cfg_rx_en(cfg_rx_en), .cfg_promisc(cfg_promisc),
    .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
);

// File: tb/sim_rxf_top.sv
module sim_rxf_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_sof = 0, in_eof = 0, in_vld = 0;
    logic [7:0]  in_data = '0;
    logic [47:0] station_addr = 48'h0211_2233_4455;
    logic [63:0] hash_table = '0;
    logic cfg_rx_en = 1, cfg_uc_en = 0, cfg_bc_en = 0, cfg_mc_all_en = 0;
    logic cfg_mc_hash_en = 0, cfg_promisc = 0, cfg_inverse = 0, cfg_sa_drop = 0;
    logic        verdict_vld, verdict_accept;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rxf_top u0 (
        .clk(clk), .rst(rst), .in_sof(in_sof), .in_eof(in_eof), .in_vld(in_vld),
        .in_data(in_data), .station_addr(station_addr), .hash_table(hash_table),
        .cfg_rx_en(cfg_rx_en), .cfg_uc_en(cfg_uc_en), .cfg_bc_en(cfg_bc_en),
        .cfg_mc_all_en(cfg_mc_all_en), .cfg_mc_hash_en(cfg_mc_hash_en),
        .cfg_promisc(cfg_promisc), .cfg_inverse(cfg_inverse), .cfg_sa_drop(cfg_sa_drop),
        .verdict_vld(verdict_vld), .verdict_accept(verdict_accept)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] ref_hash(input logic [47:0] da);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            logic [7:0] o = da[47 - 8*b -: 8];
            for (int i = 0; i < 8; i++) begin
                logic fb = c[0] ^ o[i];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        return c[31:26];
    endfunction

    function automatic logic ref_accept(input logic [47:0] da, input logic [47:0] sa,
                                        input int len, input logic en, output string tag);
        logic bc, mc, m;
        bc = (da == '1);
        mc = da[40];
        if (!en)       begin tag = "R8";  return 0; end
        if (len < 12)  begin tag = "R10"; return 0; end
        if (cfg_promisc) begin tag = "R5"; return 1; end
        if (cfg_sa_drop && sa == station_addr) begin tag = "R6"; return 0; end
        if (bc) begin
            tag = cfg_bc_en ? "R2" : "R3";
            return cfg_bc_en | cfg_mc_all_en;
        end
        if (mc) begin
            tag = cfg_mc_all_en ? "R3" : "R4";
            m = cfg_mc_all_en | (cfg_mc_hash_en & hash_table[ref_hash(da)]);
        end else begin
            tag = "R1";
            m = cfg_uc_en & (da == station_addr);
        end
        if (cfg_inverse) begin tag = "R7"; return ~m; end
        return m;
    endfunction

    // Drives one frame; flip_en toggles the receive enable after octet 3.
    task automatic send_frame(input logic [47:0] da, input logic [47:0] sa,
                              input int len, input bit flip_en, input string force_tag);
        logic  exp;
        string tag;
        exp = ref_accept(da, sa, len, cfg_rx_en, tag);
        if (force_tag != "") tag = force_tag;
        for (int p = 0; p < len; p++) begin
            @(negedge clk);
            in_vld  = 1;
            in_sof  = (p == 0);
            in_eof  = (p == len - 1);
            if (p < 6)       in_data = da[47 - 8*p -: 8];
            else if (p < 12) in_data = sa[47 - 8*(p-6) -: 8];
            else             in_data = 8'($urandom);
            if (flip_en && p == 3) cfg_rx_en = ~cfg_rx_en;
            if (p != len - 1) check("R9", verdict_vld, 1'b0, "no verdict mid-frame");
        end
        @(negedge clk);
        in_vld = 0; in_sof = 0; in_eof = 0;
        check("R9", verdict_vld, 1'b1, "verdict pulse after end");
        check(tag, verdict_accept, exp, "accept flag");
        @(negedge clk);
        check("R9", verdict_vld, 1'b0, "single verdict pulse");
    endtask

    task automatic clear_cfg();
        cfg_rx_en = 1; cfg_uc_en = 0; cfg_bc_en = 0; cfg_mc_all_en = 0;
        cfg_mc_hash_en = 0; cfg_promisc = 0; cfg_inverse = 0; cfg_sa_drop = 0;
    endtask

    initial begin
        logic [47:0] other, mcg;
        void'($urandom(32'd2024));
        other = 48'h0A00_0000_0042;
        mcg   = 48'h0100_5E00_0001;
        repeat (3) @(negedge clk);
        check("R11", verdict_vld, 1'b0, "valid in reset");
        check("R11", verdict_accept, 1'b0, "accept in reset");
        rst = 0;
        @(negedge clk);
        check("R11", verdict_vld, 1'b0, "valid after reset");

        // Directed corner cases
        clear_cfg(); cfg_uc_en = 1;
        send_frame(station_addr, other, 16, 0, "R1");
        send_frame(other, other, 16, 0, "R1");
        cfg_promisc = 1;
        send_frame(station_addr, other, 11, 0, "R10");
        send_frame(other, other, 12, 0, "R5");
        clear_cfg(); cfg_bc_en = 1;
        send_frame('1, other, 14, 0, "R2");
        clear_cfg(); cfg_mc_all_en = 1;
        send_frame('1, other, 14, 0, "R3");
        send_frame(mcg, other, 14, 0, "R3");
        clear_cfg(); cfg_inverse = 1;
        send_frame('1, other, 14, 0, "R7");
        send_frame(other, other, 14, 0, "R7");
        clear_cfg(); cfg_mc_hash_en = 1;
        hash_table = 64'd1 << ref_hash(mcg);
        send_frame(mcg, other, 14, 0, "R4");
        hash_table = ~(64'd1 << ref_hash(mcg));
        send_frame(mcg, other, 14, 0, "R4");
        clear_cfg(); cfg_uc_en = 1; cfg_sa_drop = 1;
        send_frame(station_addr, station_addr, 14, 0, "R6");
        cfg_promisc = 1;
        send_frame(station_addr, station_addr, 14, 0, "R6");
        clear_cfg(); cfg_uc_en = 1;
        send_frame(station_addr, other, 14, 1, "R8");
        send_frame(station_addr, other, 14, 1, "R8");
        cfg_rx_en = 1;

        // Random frames
        for (int n = 0; n < 400; n++) begin
            logic [47:0] da, sa;
            int len, pick;
            bit flip;
            cfg_rx_en      = ($urandom % 8) != 0;
            cfg_uc_en      = $urandom % 2;
            cfg_bc_en      = $urandom % 2;
            cfg_mc_all_en  = ($urandom % 4) == 0;
            cfg_mc_hash_en = $urandom % 2;
            cfg_promisc    = ($urandom % 6) == 0;
            cfg_inverse    = ($urandom % 5) == 0;
            cfg_sa_drop    = $urandom % 2;
            hash_table     = {$urandom, $urandom};
            pick = $urandom % 4;
            da = {$urandom, 16'($urandom)};
            case (pick)
                0: da = station_addr;
                1: da = '1;
                2: da[40] = 1'b1;
                default: da[40] = 1'b0;
            endcase
            sa = (($urandom % 3) == 0) ? station_addr : {$urandom, 16'($urandom)};
            len = (($urandom % 4) == 0) ? 1 + ($urandom % 12) : 12 + ($urandom % 9);
            flip = ($urandom % 5) == 0;
            send_frame(da, sa, len, flip, "");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule